// File: doc/BRIEF.md
# Fetch Branch Target Buffer

This block is a direct-mapped branch target buffer for the first fetch stage. Each cycle the fetch address is looked up combinationally, and the block answers with a hit flag, the predicted target and a two-bit branch kind. Branch resolution writes entries through an update port in the same cycle that a lookup may be under way. When the write lands on the slot being looked up, the lookup sees the data being written instead of the stale copy.

The valid bit of each slot lives in its own flop, apart from the tag and target storage. A single flush input clears every valid bit on one clock edge, so a thread migration cannot leave entries that produce false hits on instructions that are not branches. A later stage that finds such a false hit sends an invalidate for that one slot.

The read result comes from one of three sources, picked in a unique case: `SRC_QUIET` (flush active, result is a miss), `SRC_BYPASS` (a same-cycle update hits the looked-up slot) and `SRC_ARRAY` (stored contents). Each slot moves between two states: `EMPTY` and `LIVE`. The transition EMPTY→LIVE happens on an update. LIVE→EMPTY happens on an invalidate or a flush, and a reset or a flush puts every slot in EMPTY.

Top module: `btb_top`

## Requirements
- R1: After reset every slot is empty, so every lookup reports a miss.
- R2: The slot index is taken from address bits [IDX_W+2:3]. The tag is every address bit above the index. Address bits [2:0] do not affect the lookup.
- R3: After an update, a lookup of an address with the same index and tag hits in a later cycle. It returns the stored target and kind (kind codes: 0 conditional, 1 jump, 2 call, 3 return).
- R4: A lookup whose index holds a valid entry with a different tag reports a miss.
- R5: An update with the same index and tag as the current lookup makes that lookup hit in the same cycle. The lookup returns the update's target and kind, whatever the slot held before.
- R6: An update to the lookup's index with a different tag makes the same-cycle lookup miss.
- R7: A flush clears all valid bits on one edge. Every lookup in the cycle after it misses unless it is bypassed by an update.
- R8: While flush is high the lookup reports a miss and updates are ignored, so the written slot stays empty.
- R9: An invalidate empties its slot at the next edge, and a lookup of that slot in the same cycle reports a miss.
- R10: When an update and an invalidate target the same slot in one cycle, the update wins and the slot stays valid.
- R11: A later update to a valid slot replaces its target and kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Clears all valid bits (migration or reset) |
| rd_pc | input | PC_W | Fetch address looked up this cycle |
| rd_hit | output | 1 | Lookup hit |
| rd_target | output | PC_W | Predicted target, meaningful on hit |
| rd_kind | output | 2 | Branch kind, meaningful on hit |
| upd_en | input | 1 | Write an entry |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_target | input | PC_W | Target to store |
| upd_kind | input | 2 | Branch kind to store |
| inv_en | input | 1 | Invalidate one slot |
| inv_pc | input | PC_W | Address whose slot is invalidated |

## Verification
The properties assume that every input is held at zero while reset is asserted. This keeps the one-cycle look-backs taken just after reset release meaningful. They also assume that the bench changes inputs only at the falling edge, so the combinational lookup is settled at the rising edge. The stimulus drives all ports from one task at the falling edge and holds them quiet during reset. Besides plain sweeps, it deliberately combines flush, update and invalidate on colliding indices.

// File: rtl/btb_pkg.sv
package btb_pkg;
    typedef enum logic [1:0] {
        BK_COND = 2'd0,
        BK_JUMP = 2'd1,
        BK_CALL = 2'd2,
        BK_RET  = 2'd3
    } br_kind_e;

    typedef enum logic [1:0] {
        SRC_QUIET  = 2'd0,
        SRC_BYPASS = 2'd1,
        SRC_ARRAY  = 2'd2
    } rd_src_e;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_LIVE  = 1'b1
    } slot_state_e;
endpackage

// File: rtl/btb_idx_split.sv
module btb_idx_split #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    parameter int OFF_W = 3,
    localparam int TAG_W = PC_W - IDX_W - OFF_W
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);
    assign idx = pc[OFF_W +: IDX_W];
    assign tag = pc[PC_W-1 -: TAG_W];
endmodule

// File: rtl/btb_valid_bits.sv
module btb_valid_bits
    import btb_pkg::*;
#(
    parameter int IDX_W = 4,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid
);
    slot_state_e state_q [DEPTH];
    slot_state_e state_d [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_comb begin
            state_d[g] = state_q[g];
            unique case (state_q[g])
                SLOT_EMPTY: begin
                    if (!flush && set_en && set_idx == IDX_W'(g))
                        state_d[g] = SLOT_LIVE;
                end
                SLOT_LIVE: begin
                    if (flush)
                        state_d[g] = SLOT_EMPTY;
                    else if (set_en && set_idx == IDX_W'(g))
                        state_d[g] = SLOT_LIVE;
                    else if (clr_en && clr_idx == IDX_W'(g))
                        state_d[g] = SLOT_EMPTY;
                end
                default: state_d[g] = SLOT_EMPTY;
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) state_q[g] <= SLOT_EMPTY;
            else        state_q[g] <= state_d[g];
        end
    end

    assign rd_valid = (state_q[rd_idx] == SLOT_LIVE);
endmodule

// File: rtl/btb_entry_store.sv
module btb_entry_store #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 25,
    parameter int TGT_W = 32,
    parameter int KIND_W = 2,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [TGT_W-1:0]  wr_tgt,
    input  logic [KIND_W-1:0] wr_kind,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [TGT_W-1:0]  rd_tgt,
    output logic [KIND_W-1:0] rd_kind
);
    logic [TAG_W-1:0]  tag_mem  [DEPTH];
    logic [TGT_W-1:0]  tgt_mem  [DEPTH];
    logic [KIND_W-1:0] kind_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            tgt_mem[wr_idx]  <= wr_tgt;
            kind_mem[wr_idx] <= wr_kind;
        end
    end

    assign rd_tag  = tag_mem[rd_idx];
    assign rd_tgt  = tgt_mem[rd_idx];
    assign rd_kind = kind_mem[rd_idx];
endmodule

// File: rtl/btb_top.sv
module btb_top
    import btb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    parameter int OFF_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic [PC_W-1:0] rd_pc,
    output logic            rd_hit,
    output logic [PC_W-1:0] rd_target,
    output logic [1:0]      rd_kind,
    input  logic            upd_en,
    input  logic [PC_W-1:0] upd_pc,
    input  logic [PC_W-1:0] upd_target,
    input  logic [1:0]      upd_kind,
    input  logic            inv_en,
    input  logic [PC_W-1:0] inv_pc
);
    localparam int TAG_W = PC_W - IDX_W - OFF_W;

    logic [IDX_W-1:0] rd_idx, upd_idx, inv_idx;
    logic [TAG_W-1:0] rd_tag, upd_tag, inv_tag_unused;
    logic [TAG_W-1:0] st_tag;
    logic [PC_W-1:0]  st_tgt;
    logic [1:0]       st_kind;
    logic             st_valid;
    logic             wr_ok;
    logic             bypass, killed;
    rd_src_e          src;

    btb_idx_split #(.PC_W(PC_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split_rd (
        .pc(rd_pc), .idx(rd_idx), .tag(rd_tag));
    btb_idx_split #(.PC_W(PC_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split_upd (
        .pc(upd_pc), .idx(upd_idx), .tag(upd_tag));
    btb_idx_split #(.PC_W(PC_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split_inv (
        .pc(inv_pc), .idx(inv_idx), .tag(inv_tag_unused));

    assign wr_ok = upd_en && !flush;

    btb_valid_bits #(.IDX_W(IDX_W)) u_valid (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .set_en(upd_en), .set_idx(upd_idx),
        .clr_en(inv_en), .clr_idx(inv_idx),
        .rd_idx(rd_idx), .rd_valid(st_valid));

    btb_entry_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(PC_W), .KIND_W(2)) u_store (
        .clk(clk), .wr_en(wr_ok), .wr_idx(upd_idx), .wr_tag(upd_tag),
        .wr_tgt(upd_target), .wr_kind(upd_kind),
        .rd_idx(rd_idx), .rd_tag(st_tag), .rd_tgt(st_tgt), .rd_kind(st_kind));

    assign bypass = wr_ok && (upd_idx == rd_idx);
    assign killed = inv_en && (inv_idx == rd_idx);

    always_comb begin
        if (flush)       src = SRC_QUIET;
        else if (bypass) src = SRC_BYPASS;
        else             src = SRC_ARRAY;
    end

    always_comb begin
        rd_hit    = 1'b0;
        rd_target = st_tgt;
        rd_kind   = st_kind;
        unique case (src)
            SRC_QUIET: begin
                rd_hit = 1'b0;
            end
            SRC_BYPASS: begin
                rd_hit    = (upd_tag == rd_tag);
                rd_target = upd_target;
                rd_kind   = upd_kind;
            end
            SRC_ARRAY: begin
                rd_hit = st_valid && !killed && (st_tag == rd_tag);
            end
            default: rd_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    parameter int OFF_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            flush,
    input logic [PC_W-1:0] rd_pc,
    input logic            rd_hit,
    input logic [PC_W-1:0] rd_target,
    input logic [1:0]      rd_kind,
    input logic            upd_en,
    input logic [PC_W-1:0] upd_pc,
    input logic [PC_W-1:0] upd_target,
    input logic [1:0]      upd_kind,
    input logic            inv_en,
    input logic [PC_W-1:0] inv_pc
);
    localparam int LOW = OFF_W;

    function automatic logic [PC_W-LOW-1:0] key(input logic [PC_W-1:0] a);
        return a[PC_W-1:LOW];
    endfunction
    function automatic logic [IDX_W-1:0] slot(input logic [PC_W-1:0] a);
        return a[LOW +: IDX_W];
    endfunction

    logic upd_same_slot, inv_same_slot;
    assign upd_same_slot = upd_en && slot(upd_pc) == slot(rd_pc);
    assign inv_same_slot = inv_en && slot(inv_pc) == slot(rd_pc);

    AST_FLUSH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !rd_hit); // R8

    AST_BYPASS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !flush && key(upd_pc) == key(rd_pc))
        |-> (rd_hit && rd_target == upd_target && rd_kind == upd_kind)); // R5

    AST_BYPASS_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_same_slot && key(upd_pc) != key(rd_pc)) |-> !rd_hit); // R6

    AST_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flush) && !upd_en) |-> !rd_hit); // R7

    AST_WRITE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(upd_en && !flush) && key(rd_pc) == key($past(upd_pc))
         && !flush && !upd_same_slot && !inv_same_slot)
        |-> (rd_hit && rd_target == $past(upd_target) && rd_kind == $past(upd_kind))); // R3

    AST_INVAL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inv_en && !(upd_en && slot(upd_pc) == slot(inv_pc)))
         && slot(rd_pc) == slot($past(inv_pc)) && !upd_en) |-> !rd_hit); // R9
endmodule

bind btb_top btb_checker #(.PC_W(PC_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .rd_pc(rd_pc), .rd_hit(rd_hit),
    .rd_target(rd_target), .rd_kind(rd_kind), .upd_en(upd_en), .upd_pc(upd_pc),
    .upd_target(upd_target), .upd_kind(upd_kind), .inv_en(inv_en), .inv_pc(inv_pc));

// File: tb/btb_top_tb.sv
module btb_top_tb;
    localparam int PC_W = 32;
    localparam int IDX_W = 4;
    localparam int OFF_W = 3;
    localparam int DEPTH = 1 << IDX_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            flush = 1'b0;
    logic [PC_W-1:0] rd_pc = '0;
    logic            rd_hit;
    logic [PC_W-1:0] rd_target;
    logic [1:0]      rd_kind;
    logic            upd_en = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic [PC_W-1:0] upd_target = '0;
    logic [1:0]      upd_kind = '0;
    logic            inv_en = 1'b0;
    logic [PC_W-1:0] inv_pc = '0;

    int vectors = 0;
    int miscompares = 0;

    logic            m_valid [DEPTH];
    logic [PC_W-1:0] m_key   [DEPTH];
    logic [PC_W-1:0] m_tgt   [DEPTH];
    logic [1:0]      m_kind  [DEPTH];

    always #10 clk = ~clk;

    btb_top #(.PC_W(PC_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .rd_pc(rd_pc), .rd_hit(rd_hit),
        .rd_target(rd_target), .rd_kind(rd_kind), .upd_en(upd_en), .upd_pc(upd_pc),
        .upd_target(upd_target), .upd_kind(upd_kind), .inv_en(inv_en), .inv_pc(inv_pc));

    function automatic int slot_of(input logic [PC_W-1:0] a);
        return int'((a / 8) % DEPTH);
    endfunction
    function automatic logic [PC_W-1:0] key_of(input logic [PC_W-1:0] a);
        return a / (8 * DEPTH);
    endfunction
    function automatic logic [PC_W-1:0] mk_pc(input int tag, input int s, input int off);
        return PC_W'(tag) * (8 * DEPTH) + PC_W'(s) * 8 + PC_W'(off);
    endfunction

    task automatic vec(input string rq, input logic fl, input logic [PC_W-1:0] rpc,
                       input logic ue, input logic [PC_W-1:0] upc,
                       input logic [PC_W-1:0] utg, input logic [1:0] uk,
                       input logic ie, input logic [PC_W-1:0] ipc);
        logic            e_hit;
        logic [PC_W-1:0] e_tgt;
        logic [1:0]      e_kind;
        int              rs;
        flush = fl; rd_pc = rpc; upd_en = ue; upd_pc = upc; upd_target = utg;
        upd_kind = uk; inv_en = ie; inv_pc = ipc;
        #1;
        rs = slot_of(rpc);
        e_tgt = m_tgt[rs]; e_kind = m_kind[rs];
        if (fl) e_hit = 1'b0;
        else if (ue && slot_of(upc) == rs) begin
            e_hit = (key_of(upc) == key_of(rpc)); e_tgt = utg; e_kind = uk;
        end else
            e_hit = m_valid[rs] && !(ie && slot_of(ipc) == rs) && m_key[rs] == key_of(rpc);
        vectors++;
        if (rd_hit !== e_hit || (e_hit && (rd_target !== e_tgt || rd_kind !== e_kind))) begin
            miscompares++;
            $display("FAIL %s pc=%h actual hit=%b tgt=%h kind=%0d expected hit=%b tgt=%h kind=%0d",
                     rq, rpc, rd_hit, rd_target, rd_kind, e_hit, e_tgt, e_kind);
        end
        @(posedge clk);
        if (fl) begin
            for (int i = 0; i < DEPTH; i++) m_valid[i] = 1'b0;
        end else begin
            if (ie) m_valid[slot_of(ipc)] = 1'b0;
            if (ue) begin
                m_valid[slot_of(upc)] = 1'b1; m_key[slot_of(upc)] = key_of(upc);
                m_tgt[slot_of(upc)] = utg; m_kind[slot_of(upc)] = uk;
            end
        end
        @(negedge clk);
    endtask

    task automatic rd(input string rq, input logic [PC_W-1:0] rpc);
        vec(rq, 1'b0, rpc, 1'b0, '0, '0, 2'd0, 1'b0, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_valid[i] = 1'b0; m_key[i] = '0; m_tgt[i] = '0; m_kind[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: empty after reset
        for (int s = 0; s < DEPTH; s++) rd("R1", mk_pc(7, s, 0));
        // R3 / R2: fill every slot, read back with varied byte offsets
        for (int s = 0; s < DEPTH; s++)
            vec("R3", 1'b0, mk_pc(1, (s + 1) % DEPTH, 0), 1'b1, mk_pc(s + 3, s, 0),
                32'h4000_0000 + PC_W'(s) * 32'h44, 2'(s), 1'b0, '0);
        for (int s = 0; s < DEPTH; s++)
            for (int off = 0; off < 8; off += 3) rd("R2", mk_pc(s + 3, s, off));
        // R4: aliasing tag misses
        for (int s = 0; s < DEPTH; s++) rd("R4", mk_pc(s + 100, s, 0));
        // R5 then R11: same-cycle bypass with a new target, then persistence
        for (int s = 0; s < DEPTH; s += 3) begin
            vec("R5", 1'b0, mk_pc(s + 3, s, 4), 1'b1, mk_pc(s + 3, s, 0),
                32'h0BAD_0000 + PC_W'(s), 2'(3 - s % 4), 1'b0, '0);
            rd("R11", mk_pc(s + 3, s, 0));
        end
        // R6: update with other tag on the looked-up slot
        vec("R6", 1'b0, mk_pc(5, 2, 0), 1'b1, mk_pc(55, 2, 0), 32'h1234_5678, 2'd2, 1'b0, '0);
        rd("R4", mk_pc(5, 2, 0));
        rd("R3", mk_pc(55, 2, 0));
        // R9: invalidate, same-cycle and next-cycle miss
        vec("R9", 1'b0, mk_pc(4, 1, 0), 1'b0, '0, '0, 2'd0, 1'b1, mk_pc(4, 1, 0));
        rd("R9", mk_pc(4, 1, 0));
        rd("R3", mk_pc(6, 3, 0));
        // R10: update and invalidate on the same slot
        vec("R10", 1'b0, mk_pc(9, 5, 0), 1'b1, mk_pc(9, 6, 0), 32'hCAFE_0006, 2'd1, 1'b1, mk_pc(9, 6, 0));
        rd("R10", mk_pc(9, 6, 0));
        // R8: flush beats lookup and update
        vec("R8", 1'b1, mk_pc(10, 7, 0), 1'b1, mk_pc(10, 7, 0), 32'h7777_0000, 2'd0, 1'b0, '0);
        // R7: everything empty after the flush
        for (int s = 0; s < DEPTH; s++) rd("R7", mk_pc(s + 3, s, 0));
        rd("R8", mk_pc(10, 7, 0));
        // R7: bypass right after a flush still hits
        vec("R5", 1'b0, mk_pc(12, 8, 0), 1'b1, mk_pc(12, 8, 0), 32'h0000_8888, 2'd2, 1'b0, '0);
        rd("R3", mk_pc(12, 8, 0));
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule